// File: doc/BRIEF.md
# Register Renaming Unit with Sequence-Tagged Rollback

This block translates the architectural register numbers of a decoded instruction group into physical register numbers. It accepts up to `WIDTH` instructions per cycle. Each instruction carries one source, an optional destination and a sequence number. Sources are translated through a map table. Each destination takes the lowest-numbered free physical register. The block keeps a circular log of every destination rename, recording the sequence number, the architectural register, the new physical register and the physical register that the new one displaced.

The log serves two purposes. When the oldest logged instruction commits, its entry is dropped and the displaced physical register is released. When a squash names a sequence number, the block changes from state RUN to state UNDO. In UNDO it walks the log from the youngest end, one entry per cycle. For each entry younger than the squash point it puts the displaced mapping back into the map table and releases the register that had been allocated. The transition UNDO to RUN happens on the first cycle in which the youngest remaining entry is not younger than the squash point, or the log is empty. The transition RUN to UNDO happens on any squash request, and a squash that arrives during UNDO restarts the walk with the new point. No group is accepted during UNDO or in the cycle a squash arrives.

A group is accepted whole or not at all. A group is refused, with a stall raised, when too few free registers or too few free log entries remain. The physical register count minus the architectural count equals the log depth by default, so the two shortages coincide.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and physical registers ARCH_REGS to PHYS_REGS-1 are free. With no valid input, `grp_fire` and `grp_stall` are both 0.
- R2: A group fires (`grp_fire`=1) in the same cycle it is presented if at least one slot is valid and it is not stalled. The renamed operands appear combinationally on `out_src_phys` and `out_dst_phys` in that cycle.
- R3: A source is translated through the mapping that was in force before its own instruction's destination is renamed, so an instruction that reads and writes the same register sees the prior mapping.
- R4: Within a group, a source that matches the destination of an earlier slot receives that slot's new physical register. If two slots write the same register, the later slot wins in the map table and the later slot's displaced register is the earlier slot's new one.
- R5: Destinations of a firing group receive distinct physical registers, taken lowest-numbered free first, in ascending slot order. A slot without a destination allocates nothing, logs nothing and shows 0 on `out_dst_phys`.
- R6: When a group needs more destination registers than are free, or more log entries than remain, `grp_stall`=1 and `grp_fire`=0, and the map table and free list are left unchanged. A group with no destinations is not stalled by this condition.
- R7: A commit whose `cmt_seq` equals the sequence number of the oldest log entry removes that entry and frees its displaced register. A commit with any other sequence number is ignored.
- R8: A squash at sequence S makes the block leave RUN for UNDO. In UNDO it undoes one entry per cycle, youngest first, while that entry's sequence number is greater than S (unsigned compare). Each undo restores the displaced mapping and frees the allocated register. `grp_stall` is 1 for a valid group from the squash cycle until the block returns to RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | WIDTH | Slot holds an instruction |
| in_has_dst | input | WIDTH | Slot writes a destination register |
| in_dst | input | WIDTH x AW | Architectural destination per slot |
| in_src | input | WIDTH x AW | Architectural source per slot |
| in_seq | input | WIDTH x SEQ_W | Sequence number per slot |
| cmt_valid | input | 1 | Commit notification |
| cmt_seq | input | SEQ_W | Sequence number of the committing instruction |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Entries with a larger sequence number are undone |
| grp_fire | output | 1 | Group accepted this cycle |
| grp_stall | output | 1 | Group refused this cycle |
| out_src_phys | output | WIDTH x PW | Physical source per slot |
| out_dst_phys | output | WIDTH x PW | Newly allocated physical destination per slot |

## Verification
A corrupted map entry shows up on `out_src_phys` the first time a later group reads that register. After a squash this is the cycle the block returns to RUN. A lost or doubly freed register shows up at the next allocation as an unexpected `out_dst_phys` value, or later as a stall while the log still has room. A wrong stop point in the undo walk changes the number of stalled cycles after a squash, and it changes which physical register the squashed-over register maps to afterwards.

// File: rtl/rr_pkg.sv
package rr_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_UNDO = 1'b1
    } rr_state_e;
endpackage

// File: rtl/rr_maptable.sv
module rr_maptable #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 16,
    parameter int NRD       = 4,
    parameter int NWR       = 3,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NRD-1:0][AW-1:0]   rd_idx,
    output logic [NRD-1:0][PW-1:0]   rd_data,
    input  logic [NWR-1:0]           wr_en,
    input  logic [NWR-1:0][AW-1:0]   wr_idx,
    input  logic [NWR-1:0][PW-1:0]   wr_data
);
    logic [PW-1:0] map_q [ARCH_REGS];

    always_comb begin
        for (int r = 0; r < NRD; r++) rd_data[r] = map_q[rd_idx[r]];
    end

    // Higher write ports take priority: later slots in a group overwrite earlier ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
        end else begin
            for (int w = 0; w < NWR; w++)
                if (wr_en[w]) map_q[wr_idx[w]] <= wr_data[w];
        end
    end
endmodule

// File: rtl/rr_freelist.sv
module rr_freelist #(
    parameter int PHYS_REGS = 16,
    parameter int ARCH_REGS = 8,
    parameter int WIDTH     = 2,
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WIDTH-1:0]          want,
    input  logic                      take,
    input  logic [1:0]                rel_en,
    input  logic [1:0][PW-1:0]        rel_idx,
    output logic                      ok,
    output logic [WIDTH-1:0][PW-1:0]  grant
);
    logic [PHYS_REGS-1:0] free_q, avail, clr_mask, set_mask;
    logic found;

    // Lowest-index-first pick, slot by slot, removing each pick before the next slot.
    always_comb begin
        avail    = free_q;
        ok       = 1'b1;
        clr_mask = '0;
        found    = 1'b0;
        for (int k = 0; k < WIDTH; k++) begin
            grant[k] = '0;
            found    = 1'b0;
            if (want[k]) begin
                for (int p = 0; p < PHYS_REGS; p++) begin
                    if (!found && avail[p]) begin
                        grant[k] = PW'(p);
                        found    = 1'b1;
                    end
                end
                if (found) begin
                    avail[grant[k]]    = 1'b0;
                    clr_mask[grant[k]] = 1'b1;
                end else begin
                    ok = 1'b0;
                end
            end
        end
    end

    always_comb begin
        set_mask = '0;
        for (int r = 0; r < 2; r++)
            if (rel_en[r]) set_mask[rel_idx[r]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PHYS_REGS; p++) free_q[p] <= (p >= ARCH_REGS);
        end else if (take && ok) begin
            free_q <= (free_q & ~clr_mask) | set_mask;
        end else begin
            free_q <= free_q | set_mask;
        end
    end

    // A register released by commit must not already be free.
    assert_no_double_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en[0] |-> !free_q[rel_idx[0]]);
    // A register released by the undo walk must not already be free.
    assert_no_double_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en[1] |-> !free_q[rel_idx[1]]);
endmodule

// File: rtl/rr_history.sv
module rr_history #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 2,
    parameter int AW    = 3,
    parameter int PW    = 4,
    parameter int SW    = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WIDTH-1:0]          push_en,
    input  logic [WIDTH-1:0][AW-1:0]  push_arch,
    input  logic [WIDTH-1:0][PW-1:0]  push_new,
    input  logic [WIDTH-1:0][PW-1:0]  push_old,
    input  logic [WIDTH-1:0][SW-1:0]  push_seq,
    input  logic                      pop_head,
    input  logic                      pop_tail,
    output logic [CW-1:0]             count,
    output logic [SW-1:0]             head_seq,
    output logic [PW-1:0]             head_old,
    output logic [AW-1:0]             tail_arch,
    output logic [PW-1:0]             tail_new,
    output logic [PW-1:0]             tail_old,
    output logic [SW-1:0]             tail_seq
);
    logic [AW-1:0] arch_m [DEPTH];
    logic [PW-1:0] new_m  [DEPTH];
    logic [PW-1:0] old_m  [DEPTH];
    logic [SW-1:0] seq_m  [DEPTH];
    logic [IW-1:0] head_q, tail_q, young;
    logic [CW-1:0] count_q, npush;
    logic [WIDTH-1:0][IW-1:0] slot_pos;

    always_comb begin
        npush = '0;
        for (int k = 0; k < WIDTH; k++) begin
            slot_pos[k] = tail_q + IW'(npush);
            if (push_en[k]) npush = npush + 1'b1;
        end
    end

    assign young     = tail_q - 1'b1;
    assign count     = count_q;
    assign head_seq  = seq_m[head_q];
    assign head_old  = old_m[head_q];
    assign tail_arch = arch_m[young];
    assign tail_new  = new_m[young];
    assign tail_old  = old_m[young];
    assign tail_seq  = seq_m[young];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            head_q  <= head_q + IW'(pop_head);
            tail_q  <= tail_q + IW'(npush) - IW'(pop_tail);
            count_q <= count_q + npush - CW'(pop_head) - CW'(pop_tail);
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < WIDTH; k++) begin
            if (push_en[k]) begin
                arch_m[slot_pos[k]] <= push_arch[k];
                new_m[slot_pos[k]]  <= push_new[k];
                old_m[slot_pos[k]]  <= push_old[k];
                seq_m[slot_pos[k]]  <= push_seq[k];
            end
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|push_en) |-> (32'(count_q) + 32'(npush) <= DEPTH));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_head || pop_tail) |-> (count_q != '0));
endmodule

// File: rtl/reg_rename.sv
module reg_rename
    import rr_pkg::*;
#(
    parameter int ARCH_REGS  = 8,
    parameter int PHYS_REGS  = 16,
    parameter int WIDTH      = 2,
    parameter int HIST_DEPTH = 8,
    parameter int SEQ_W      = 8,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS),
    localparam int CW = $clog2(HIST_DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WIDTH-1:0]           in_valid,
    input  logic [WIDTH-1:0]           in_has_dst,
    input  logic [WIDTH-1:0][AW-1:0]   in_dst,
    input  logic [WIDTH-1:0][AW-1:0]   in_src,
    input  logic [WIDTH-1:0][SEQ_W-1:0] in_seq,
    input  logic                       cmt_valid,
    input  logic [SEQ_W-1:0]           cmt_seq,
    input  logic                       sq_valid,
    input  logic [SEQ_W-1:0]           sq_seq,
    output logic                       grp_fire,
    output logic                       grp_stall,
    output logic [WIDTH-1:0][PW-1:0]   out_src_phys,
    output logic [WIDTH-1:0][PW-1:0]   out_dst_phys
);
    rr_state_e state_q, state_d;
    logic [SEQ_W-1:0] sq_hold_q;

    logic [WIDTH-1:0]               need;
    logic                           any_valid, room_ok, fl_ok, shortage;
    logic [WIDTH-1:0][PW-1:0]       grant, old_phys;
    logic [2*WIDTH-1:0][AW-1:0]     rd_idx;
    logic [2*WIDTH-1:0][PW-1:0]     rd_data;
    logic [WIDTH:0]                 wr_en;
    logic [WIDTH:0][AW-1:0]         wr_idx;
    logic [WIDTH:0][PW-1:0]         wr_data;
    logic [CW-1:0]                  hist_count;
    logic [SEQ_W-1:0]               head_seq, tail_seq;
    logic [PW-1:0]                  head_old, tail_new, tail_old;
    logic [AW-1:0]                  tail_arch;
    logic                           cmt_pop, undo_pop;

    assign need      = in_valid & in_has_dst;
    assign any_valid = |in_valid;
    assign room_ok   = (32'(hist_count) + 32'($countones(need))) <= HIST_DEPTH;
    assign shortage  = !fl_ok || !room_ok;

    assign cmt_pop  = cmt_valid && (hist_count != '0) && (head_seq == cmt_seq);
    assign undo_pop = (state_q == ST_UNDO) && (32'(hist_count) > 32'(cmt_pop))
                      && (tail_seq > sq_hold_q);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            sq_hold_q <= '0;
        end else begin
            state_q <= state_d;
            if (sq_valid) sq_hold_q <= sq_seq;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d   = state_q;
        grp_stall = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (sq_valid) state_d = ST_UNDO;
                grp_stall = any_valid && (sq_valid || shortage);
            end
            ST_UNDO: begin
                if (!undo_pop && !sq_valid) state_d = ST_RUN;
                grp_stall = any_valid;
            end
            default: state_d = ST_RUN;
        endcase
        grp_fire = any_valid && !grp_stall;
    end

    // Lookups with in-group forwarding from earlier slots.
    always_comb begin
        for (int k = 0; k < WIDTH; k++) begin
            rd_idx[k]         = in_src[k];
            rd_idx[WIDTH + k] = in_dst[k];
        end
        for (int k = 0; k < WIDTH; k++) begin
            out_src_phys[k] = rd_data[k];
            old_phys[k]     = rd_data[WIDTH + k];
            for (int j = 0; j < k; j++) begin
                if (need[j] && in_dst[j] == in_src[k]) out_src_phys[k] = grant[j];
                if (need[j] && in_dst[j] == in_dst[k]) old_phys[k]     = grant[j];
            end
            out_dst_phys[k] = need[k] ? grant[k] : '0;
            wr_en[k]   = grp_fire && need[k];
            wr_idx[k]  = in_dst[k];
            wr_data[k] = grant[k];
        end
        wr_en[WIDTH]   = undo_pop;
        wr_idx[WIDTH]  = tail_arch;
        wr_data[WIDTH] = tail_old;
    end

    rr_maptable #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS),
                  .NRD(2*WIDTH), .NWR(WIDTH+1)) u_map (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

    rr_freelist #(.PHYS_REGS(PHYS_REGS), .ARCH_REGS(ARCH_REGS), .WIDTH(WIDTH)) u_free (
        .clk(clk), .rst_n(rst_n), .want(need), .take(grp_fire),
        .rel_en({undo_pop, cmt_pop}), .rel_idx({tail_new, head_old}),
        .ok(fl_ok), .grant(grant));

    rr_history #(.DEPTH(HIST_DEPTH), .WIDTH(WIDTH), .AW(AW), .PW(PW), .SW(SEQ_W)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .push_en(need & {WIDTH{grp_fire}}), .push_arch(in_dst), .push_new(grant),
        .push_old(old_phys), .push_seq(in_seq),
        .pop_head(cmt_pop), .pop_tail(undo_pop),
        .count(hist_count), .head_seq(head_seq), .head_old(head_old),
        .tail_arch(tail_arch), .tail_new(tail_new), .tail_old(tail_old), .tail_seq(tail_seq));

    assert_squash_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> !grp_fire);
    assert_undo_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNDO && hist_count == '0 && !sq_valid) |=> (state_q == ST_RUN));

    for (genvar i = 0; i < WIDTH; i++) begin : g_pair_i
        for (genvar j = i + 1; j < WIDTH; j++) begin : g_pair_j
            assert_distinct_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (grp_fire && need[i] && need[j]) |-> (out_dst_phys[i] != out_dst_phys[j]));
        end
    end
endmodule

// File: tb/reg_rename_tb.sv
module reg_rename_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]       in_valid, in_has_dst;
    logic [1:0][2:0]  in_dst, in_src;
    logic [1:0][7:0]  in_seq;
    logic             cmt_valid, sq_valid;
    logic [7:0]       cmt_seq, sq_seq;
    logic             grp_fire, grp_stall;
    logic [1:0][3:0]  out_src_phys, out_dst_phys;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    reg_rename u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_has_dst(in_has_dst),
        .in_dst(in_dst), .in_src(in_src), .in_seq(in_seq),
        .cmt_valid(cmt_valid), .cmt_seq(cmt_seq), .sq_valid(sq_valid), .sq_seq(sq_seq),
        .grp_fire(grp_fire), .grp_stall(grp_stall),
        .out_src_phys(out_src_phys), .out_dst_phys(out_dst_phys));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        in_valid = '0; in_has_dst = '0; in_dst = '0; in_src = '0; in_seq = '0;
        cmt_valid = 0; cmt_seq = '0; sq_valid = 0; sq_seq = '0;
    endtask

    task automatic slot(input int k, input bit has, input int dst, input int src, input int seq);
        in_valid[k] = 1'b1; in_has_dst[k] = has;
        in_dst[k] = 3'(dst); in_src[k] = 3'(src); in_seq[k] = 8'(seq);
    endtask

    // Inputs set at the falling edge, outputs sampled 1 ns later.
    task automatic begin_step();
        @(negedge clk);
        clear_in();
    endtask
    task automatic end_step();
        @(posedge clk);
        #1 clear_in();
    endtask

    task automatic t_reset();
        begin_step(); #1;
        chk("R1 idle fire", grp_fire, 0);
        chk("R1 idle stall", grp_stall, 0);
        end_step();
        begin_step(); slot(0, 0, 0, 3, 0); #1;
        chk("R2 fire", grp_fire, 1);
        chk("R1 reset map src3", out_src_phys[0], 3);
        chk("R5 no dst shows 0", out_dst_phys[0], 0);
        end_step();
    endtask

    task automatic t_group();
        begin_step(); slot(0, 1, 1, 1, 1); slot(1, 1, 2, 1, 2); #1;
        chk("R2 fire", grp_fire, 1);
        chk("R3 src before own dst", out_src_phys[0], 1);
        chk("R5 slot0 dst", out_dst_phys[0], 8);
        chk("R4 bypass src", out_src_phys[1], 8);
        chk("R5 slot1 dst", out_dst_phys[1], 9);
        end_step();
        begin_step(); slot(0, 1, 1, 2, 3); slot(1, 1, 1, 1, 4); #1;
        chk("R4 src2", out_src_phys[0], 9);
        chk("R5 dst", out_dst_phys[0], 10);
        chk("R4 same dst bypass", out_src_phys[1], 10);
        chk("R5 dst", out_dst_phys[1], 11);
        end_step();
        begin_step(); slot(0, 0, 0, 1, 5); slot(1, 0, 0, 2, 5); #1;
        chk("R4 last writer wins", out_src_phys[0], 11);
        chk("R4 map2", out_src_phys[1], 9);
        end_step();
    endtask

    task automatic t_squash();
        int n = 0;
        begin_step(); slot(0, 0, 0, 1, 9); sq_valid = 1; sq_seq = 8'd2; #1;
        chk("R8 stall on squash", grp_stall, 1);
        chk("R8 no fire on squash", grp_fire, 0);
        @(posedge clk); #1 begin sq_valid = 0; end
        @(negedge clk); #1;
        while (grp_stall && n < 20) begin
            n++;
            @(negedge clk); #1;
        end
        chk("R8 walk length", n, 3);
        chk("R8 restored src1", out_src_phys[0], 8);
        end_step();
        begin_step(); slot(0, 0, 0, 2, 9); #1;
        chk("R8 older mapping kept", out_src_phys[0], 9);
        end_step();
        begin_step(); slot(0, 1, 3, 3, 3); #1;
        chk("R8 undone register reused", out_dst_phys[0], 10);
        end_step();
    endtask

    task automatic t_commit();
        begin_step(); cmt_valid = 1; cmt_seq = 8'd5; end_step();
        begin_step(); slot(0, 1, 4, 0, 4); #1;
        chk("R7 mismatched commit ignored", out_dst_phys[0], 11);
        end_step();
        begin_step(); cmt_valid = 1; cmt_seq = 8'd1; end_step();
        begin_step(); slot(0, 1, 5, 0, 5); #1;
        chk("R7 commit frees old", out_dst_phys[0], 1);
        end_step();
    endtask

    task automatic t_stall();
        begin_step(); slot(0, 1, 6, 0, 6); slot(1, 1, 7, 0, 7); #1;
        chk("R5 dst", out_dst_phys[0], 12);
        chk("R5 dst", out_dst_phys[1], 13);
        end_step();
        begin_step(); slot(0, 1, 6, 6, 8); slot(1, 1, 7, 0, 9); #1;
        chk("R5 dst", out_dst_phys[0], 14);
        chk("R5 dst", out_dst_phys[1], 15);
        end_step();
        begin_step(); slot(0, 1, 0, 0, 10); #1;
        chk("R6 stall when empty", grp_stall, 1);
        chk("R6 no fire", grp_fire, 0);
        end_step();
        begin_step(); slot(0, 0, 0, 6, 10); slot(1, 0, 0, 0, 10); #1;
        chk("R6 no-dst group fires", grp_fire, 1);
        chk("R6 src6", out_src_phys[0], 14);
        chk("R6 stalled group left map", out_src_phys[1], 0);
        end_step();
        begin_step(); cmt_valid = 1; cmt_seq = 8'd2; end_step();
        begin_step(); slot(0, 1, 0, 0, 10); slot(1, 1, 1, 0, 11); #1;
        chk("R6 partial shortage stalls", grp_stall, 1);
        end_step();
        begin_step(); slot(0, 1, 0, 0, 10); #1;
        chk("R6 single fits", grp_fire, 1);
        chk("R6 stalled group took nothing", out_dst_phys[0], 2);
        end_step();
    endtask

    initial begin
        clear_in();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_group();
        t_squash();
        t_commit();
        t_stall();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule